// File: doc/BRIEF.md
# Registered 8-bit Arithmetic/Logic Unit with Result Feedback

This block is a small arithmetic/logic datapath with its own registers. It holds two operand registers, a 4-bit instruction register and an 8-bit result register, along with three registered status flags. Each operand register loads either from the external 8-bit data bus or from the current result. Because of this, a chain of operations can run without the result ever leaving the block.

On every clock edge the result register captures the output of the operation held in the instruction register. That operation works on the operand values held before the edge. Every operator computes in parallel, and the decoded instruction picks which output is written. Increment and decrement share the adder: a constant +1 or -1 replaces operand B on the adder's second input. The instruction is registered one edge ahead of execution, so the control signals are already settled when the operands are used. Shifts take a selectable fill bit and record the bit pushed out.

Top module: `chain_alu`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge clears both operand registers, the instruction register, the result and all three flags to zero.
- R2: When `load_a` is high, operand A takes `data_in`, or takes the pre-edge result when `a_from_res` is high. The same rule applies to `load_b` and `b_from_res` for operand B. An operand register that is not loaded keeps its value.
- R3: Opcode 0 (add) writes A+B modulo 256. The overflow flag then shows signed two's-complement overflow, and the shifted-out flag is cleared.
- R4: Opcode 1 (increment) writes A+1 and opcode 2 (decrement) writes A-1, both ignoring B. Overflow is set only for increment of 0x7F and for decrement of 0x80.
- R5: Opcode 3 (negate) writes 0-A. Overflow is set only when A is 0x80.
- R6: Opcode 4 writes the bitwise NOT of A, opcode 5 writes A OR B and opcode 6 writes A AND B. These operations clear the overflow and shifted-out flags.
- R7: Opcodes 7 and 8 shift A left by one place, with fill bit 0 and 1 respectively entering bit 0. The shifted-out flag takes the old bit 7 and overflow is cleared.
- R8: Opcodes 9 and 10 shift A right by one place, with fill bit 0 and 1 respectively entering bit 7. The shifted-out flag takes the old bit 0 and overflow is cleared.
- R9: After any executed opcode (0 to 10), the zero flag is 1 exactly when the new result is 0x00.
- R10: Opcodes 11 to 15 change neither the result nor any flag.
- R11: The instruction register loads `instr_in` only when `instr_wr` is high. The operation executed at an edge is the one registered before that edge, and it uses the pre-edge operand values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 8 | External operand data bus |
| load_a | input | 1 | Load enable for operand A |
| a_from_res | input | 1 | Operand A source: 0 data_in, 1 result |
| load_b | input | 1 | Load enable for operand B |
| b_from_res | input | 1 | Operand B source: 0 data_in, 1 result |
| instr_wr | input | 1 | Load enable for the instruction register |
| instr_in | input | 4 | Opcode to register |
| result | output | 8 | Result register |
| zero_flag | output | 1 | Last executed result was zero |
| ovf_flag | output | 1 | Signed overflow of last executed operation |
| shout_flag | output | 1 | Bit shifted out by last shift |

## Verification
The hardest situation to reach is one where the instruction register, an operand reload and a result feedback all change on the same edge. In that case the executed operation must use only pre-edge values. A reversed ordering would show up only in those cycles. The directed part of the stimulus chains a result back into operand A on the same edge that a new opcode is written. It also writes a no-op while the operand beneath it changes. The seeded random part then lets loads, feedback selects, opcode writes and occasional resets collide freely, and every cycle is compared against a cycle model.

// File: rtl/chain_alu_pkg.sv
// Package: shared opcode values, operator selects and the decoded control word.
// Assumes a 4-bit opcode field; opcodes above OPC_SHR1 decode as no-op.
package chain_alu_pkg;
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_ADD  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_INC  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_DEC  = 4'd2;
    localparam logic [OPC_W-1:0] OPC_NEG  = 4'd3;
    localparam logic [OPC_W-1:0] OPC_NOT  = 4'd4;
    localparam logic [OPC_W-1:0] OPC_OR   = 4'd5;
    localparam logic [OPC_W-1:0] OPC_AND  = 4'd6;
    localparam logic [OPC_W-1:0] OPC_SHL0 = 4'd7;
    localparam logic [OPC_W-1:0] OPC_SHL1 = 4'd8;
    localparam logic [OPC_W-1:0] OPC_SHR0 = 4'd9;
    localparam logic [OPC_W-1:0] OPC_SHR1 = 4'd10;

    typedef enum logic [2:0] {
        SEL_SUM, SEL_NEG, SEL_NOT, SEL_OR, SEL_AND, SEL_SHL, SEL_SHR
    } sel_e;

    typedef enum logic [1:0] {
        BSRC_REG, BSRC_PLUS1, BSRC_MINUS1
    } bsrc_e;

    typedef struct packed {
        logic  exec;
        sel_e  sel;
        bsrc_e bsrc;
        logic  fill;
    } ctrl_t;
endpackage

// File: rtl/calu_decode.sv
// Module: calu_decode
// Turns the registered opcode into the control word for the operator bank.
// Purely combinational; unknown opcodes give exec=0 so the result side holds.
module calu_decode
    import chain_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output ctrl_t            ctrl
);
    // Map each opcode to operator select, adder B source and shift fill
    always_comb begin
        ctrl = '{exec: 1'b1, sel: SEL_SUM, bsrc: BSRC_REG, fill: 1'b0};
        case (opc)
            OPC_ADD:  ctrl.sel = SEL_SUM;
            OPC_INC:  ctrl.bsrc = BSRC_PLUS1;
            OPC_DEC:  ctrl.bsrc = BSRC_MINUS1;
            OPC_NEG:  ctrl.sel = SEL_NEG;
            OPC_NOT:  ctrl.sel = SEL_NOT;
            OPC_OR:   ctrl.sel = SEL_OR;
            OPC_AND:  ctrl.sel = SEL_AND;
            OPC_SHL0: ctrl.sel = SEL_SHL;
            OPC_SHL1: begin ctrl.sel = SEL_SHL; ctrl.fill = 1'b1; end
            OPC_SHR0: ctrl.sel = SEL_SHR;
            OPC_SHR1: begin ctrl.sel = SEL_SHR; ctrl.fill = 1'b1; end
            default:  ctrl.exec = 1'b0;
        endcase
    end
endmodule

// File: rtl/calu_ops.sv
// Module: calu_ops
// Operator bank: all operators evaluate at once from A and B, then one
// output is selected. Increment/decrement reuse the adder by substituting
// a constant for B. Assumes W >= 2.
module calu_ops
    import chain_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  ctrl_t        ctrl,
    output logic [W-1:0] res,
    output logic         ovf,
    output logic         shout
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W-1:0] sum, neg, shl, shr;
    logic         sum_ovf, neg_ovf;

    // Pick the adder's second operand: register B or a +1/-1 constant
    always_comb begin
        case (ctrl.bsrc)
            BSRC_PLUS1:  b_eff = W'(1);
            BSRC_MINUS1: b_eff = '1;
            default:     b_eff = opb;
        endcase
    end

    // Parallel arithmetic and shift results with their overflow terms
    always_comb begin
        sum     = opa + b_eff;
        sum_ovf = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
        neg     = '0 - opa;
        neg_ovf = opa[MSB] & neg[MSB];
        shl     = {opa[MSB-1:0], ctrl.fill};
        shr     = {ctrl.fill, opa[MSB:1]};
    end

    // Route the selected operator and its flag terms to the outputs
    always_comb begin
        ovf   = 1'b0;
        shout = 1'b0;
        case (ctrl.sel)
            SEL_SUM: begin res = sum; ovf = sum_ovf; end
            SEL_NEG: begin res = neg; ovf = neg_ovf; end
            SEL_NOT: res = ~opa;
            SEL_OR:  res = opa | opb;
            SEL_AND: res = opa & opb;
            SEL_SHL: begin res = shl; shout = opa[MSB]; end
            SEL_SHR: begin res = shr; shout = opa[0]; end
            default: res = sum;
        endcase
    end
endmodule

// File: rtl/calu_opreg.sv
// Module: calu_opreg
// One operand register with a two-way source: external bus or result feedback.
// Synchronous active-low reset; holds when not loaded.
module calu_opreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         from_res,
    input  logic [W-1:0] bus_in,
    input  logic [W-1:0] res_in,
    output logic [W-1:0] q
);
    // Capture the chosen source on load, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= from_res ? res_in : bus_in;
    end
endmodule

// File: rtl/chain_alu.sv
// Module: chain_alu (top)
// Registered ALU: opcode register, two operand registers with result
// feedback, an operator bank, and a result register with three flags.
// The opcode is registered one edge before it executes, so decode is
// settled from the register output while operands are captured.
module chain_alu
    import chain_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     data_in,
    input  logic             load_a,
    input  logic             a_from_res,
    input  logic             load_b,
    input  logic             b_from_res,
    input  logic             instr_wr,
    input  logic [OPC_W-1:0] instr_in,
    output logic [W-1:0]     result,
    output logic             zero_flag,
    output logic             ovf_flag,
    output logic             shout_flag
);
    localparam int N_OPR = 2;

    logic [OPC_W-1:0] instr_q;
    logic [W-1:0]     opr_q [N_OPR];
    logic [N_OPR-1:0] load_v, src_v;
    logic [W-1:0]     opr_a, opr_b;
    ctrl_t            ctrl;
    logic [W-1:0]     op_res;
    logic             op_ovf, op_shout;

    assign load_v = {load_b, load_a};
    assign src_v  = {b_from_res, a_from_res};
    assign opr_a  = opr_q[0];
    assign opr_b  = opr_q[1];

    // Instruction register: written only on instr_wr
    always_ff @(posedge clk) begin
        if (!rst_n)        instr_q <= '0;
        else if (instr_wr) instr_q <= instr_in;
    end

    for (genvar gi = 0; gi < N_OPR; gi++) begin : g_opr
        calu_opreg #(.W(W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_v[gi]),
            .from_res(src_v[gi]),
            .bus_in  (data_in),
            .res_in  (result),
            .q       (opr_q[gi])
        );
    end

    calu_decode u_dec (
        .opc (instr_q),
        .ctrl(ctrl)
    );

    calu_ops #(.W(W)) u_ops (
        .opa  (opr_a),
        .opb  (opr_b),
        .ctrl (ctrl),
        .res  (op_res),
        .ovf  (op_ovf),
        .shout(op_shout)
    );

    // Result and flags: update on executed opcodes, hold on no-op
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result     <= '0;
            zero_flag  <= 1'b0;
            ovf_flag   <= 1'b0;
            shout_flag <= 1'b0;
        end else if (ctrl.exec) begin
            result     <= op_res;
            zero_flag  <= (op_res == '0);
            ovf_flag   <= op_ovf;
            shout_flag <= op_shout;
        end
    end
endmodule

// File: rtl/chain_alu_chk.sv
// Module: chain_alu_chk
// Property checker bound into chain_alu; observes the opcode register,
// operand A and the registered outputs.
module chain_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   ir,
    input logic [W-1:0] opa,
    input logic [W-1:0] result,
    input logic         zero_flag,
    input logic         ovf_flag,
    input logic         shout_flag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (result == '0 && !zero_flag && !ovf_flag && !shout_flag));

    // R10
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir >= 4'd11) |=> ($stable(result) && $stable(zero_flag)
                           && $stable(ovf_flag) && $stable(shout_flag)));

    // R7
    shl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir == 4'd7 || ir == 4'd8) |=>
            (result == {$past(opa[W-2:0]), $past(ir) == 4'd8}
             && shout_flag == $past(opa[W-1]) && !ovf_flag));

    // R5
    neg_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir == 4'd3) |=> (ovf_flag == ($past(opa) == MOST_NEG)));

    // R6
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir >= 4'd4 && ir <= 4'd6) |=> (!ovf_flag && !shout_flag));

    // R9
    zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ir <= 4'd10) |=> (zero_flag == (result == '0)));
endmodule

bind chain_alu chain_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ir        (instr_q),
    .opa       (opr_a),
    .result    (result),
    .zero_flag (zero_flag),
    .ovf_flag  (ovf_flag),
    .shout_flag(shout_flag)
);

// File: tb/tb_chain_alu.sv
// Bench for chain_alu: cycle model, directed corners, seeded random stimulus.
`timescale 1ns/100ps
module tb_chain_alu;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] data_in = '0;
    logic         load_a = 0, a_from_res = 0, load_b = 0, b_from_res = 0;
    logic         instr_wr = 0;
    logic [3:0]   instr_in = '0;
    logic [W-1:0] result;
    logic         zero_flag, ovf_flag, shout_flag;

    always #2.5 clk = ~clk;

    chain_alu #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .data_in(data_in),
        .load_a(load_a), .a_from_res(a_from_res),
        .load_b(load_b), .b_from_res(b_from_res),
        .instr_wr(instr_wr), .instr_in(instr_in),
        .result(result), .zero_flag(zero_flag),
        .ovf_flag(ovf_flag), .shout_flag(shout_flag)
    );

    int total = 0, fails = 0;
    bit done = 0;

    // bench cycle model
    logic [7:0] m_a, m_b, m_r;
    logic [3:0] m_ir;
    logic       m_z, m_o, m_s;

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0:        return "R3";
            4'd1, 4'd2:  return "R4";
            4'd3:        return "R5";
            4'd4, 4'd5, 4'd6: return "R6";
            4'd7, 4'd8:  return "R7";
            4'd9, 4'd10: return "R8";
            default:     return "R10";
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk(tag,  "result", result, m_r);
        chk("R9", "zero",   {7'd0, zero_flag}, {7'd0, m_z});
        chk(tag,  "ovf",    {7'd0, ovf_flag},  {7'd0, m_o});
        chk(tag,  "shout",  {7'd0, shout_flag}, {7'd0, m_s});
    endtask

    // One clock: drive at negedge, model the edge, compare at next negedge
    task automatic step(input bit la, input bit sa, input bit lb, input bit sb,
                        input bit iw, input logic [3:0] op, input logic [7:0] d);
        int ia, s;
        logic [7:0] nr;
        logic no, ns, ex;
        logic [3:0] old_ir;
        load_a = la; a_from_res = sa; load_b = lb; b_from_res = sb;
        instr_wr = iw; instr_in = op; data_in = d;
        @(posedge clk);
        old_ir = m_ir;
        ia = int'($signed(m_a));
        ex = 1'b1; no = 1'b0; ns = 1'b0; nr = m_r;
        case (m_ir)
            4'd0: begin s = ia + int'($signed(m_b)); nr = m_a + m_b; no = (s > 127 || s < -128); end
            4'd1: begin s = ia + 1; nr = m_a + 8'd1; no = (s > 127); end
            4'd2: begin s = ia - 1; nr = m_a - 8'd1; no = (s < -128); end
            4'd3: begin s = -ia; nr = 8'(s); no = (s > 127); end
            4'd4: nr = ~m_a;
            4'd5: nr = m_a | m_b;
            4'd6: nr = m_a & m_b;
            4'd7: begin nr = {m_a[6:0], 1'b0}; ns = m_a[7]; end
            4'd8: begin nr = {m_a[6:0], 1'b1}; ns = m_a[7]; end
            4'd9: begin nr = {1'b0, m_a[7:1]}; ns = m_a[0]; end
            4'd10: begin nr = {1'b1, m_a[7:1]}; ns = m_a[0]; end
            default: ex = 1'b0;
        endcase
        if (la) m_a = sa ? m_r : d;
        if (lb) m_b = sb ? m_r : d;
        if (iw) m_ir = op;
        if (ex) begin m_r = nr; m_z = (nr == 8'd0); m_o = no; m_s = ns; end
        @(negedge clk);
        compare_all(tag_of(old_ir));
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 4'd0, 8'd0);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(posedge clk);
        m_a = 0; m_b = 0; m_r = 0; m_ir = 0; m_z = 0; m_o = 0; m_s = 0;
        @(negedge clk);
        chk("R1", "result", result, 8'h00);
        chk("R1", "zero",   {7'd0, zero_flag}, 8'h00);
        chk("R1", "ovf",    {7'd0, ovf_flag}, 8'h00);
        chk("R1", "shout",  {7'd0, shout_flag}, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();

        // R3: 0x7F + 0x01 overflows to 0x80
        step(1, 0, 0, 0, 1, 4'd0, 8'h7F);
        step(0, 0, 1, 0, 0, 4'd0, 8'h01);
        idle();
        chk("R3", "add result", result, 8'h80);
        chk("R3", "add ovf", {7'd0, ovf_flag}, 8'h01);

        // R4: increment of 0x7F overflows
        step(0, 0, 0, 0, 1, 4'd1, 8'h00);
        idle();
        chk("R4", "inc result", result, 8'h80);
        chk("R4", "inc ovf", {7'd0, ovf_flag}, 8'h01);

        // R4: decrement of 0x80 overflows
        step(1, 0, 0, 0, 1, 4'd2, 8'h80);
        idle();
        chk("R4", "dec result", result, 8'h7F);
        chk("R4", "dec ovf", {7'd0, ovf_flag}, 8'h01);

        // R5: negate of 0x80 overflows, negate of 0 does not and is zero
        step(0, 0, 0, 0, 1, 4'd3, 8'h00);
        idle();
        chk("R5", "neg80 ovf", {7'd0, ovf_flag}, 8'h01);
        step(1, 0, 0, 0, 0, 4'd0, 8'h00);
        idle();
        chk("R5", "neg0 ovf", {7'd0, ovf_flag}, 8'h00);
        chk("R9", "neg0 zero", {7'd0, zero_flag}, 8'h01);

        // R7: shift left fill 1 of 0x81
        step(1, 0, 0, 0, 1, 4'd8, 8'h81);
        idle();
        chk("R7", "shl1 result", result, 8'h03);
        chk("R7", "shl1 shout", {7'd0, shout_flag}, 8'h01);

        // R8: shift right fill 1 of 0x81
        step(0, 0, 0, 0, 1, 4'd10, 8'h00);
        idle();
        chk("R8", "shr1 result", result, 8'hC0);
        chk("R8", "shr1 shout", {7'd0, shout_flag}, 8'h01);

        // R2: feed the result back into A, then NOT it
        step(1, 1, 0, 0, 1, 4'd4, 8'h00);
        idle();
        chk("R2", "feedback not", result, 8'h3F);

        // R11: opcode presented with instr_wr low is not taken
        step(0, 0, 0, 0, 0, 4'd0, 8'h00);
        idle();
        chk("R11", "wr low keeps op", result, 8'h3F);

        // R10: no-op holds result while A changes
        step(1, 0, 0, 0, 1, 4'd12, 8'h55);
        idle();
        idle();
        chk("R10", "nop hold", result, 8'h3F);

        do_reset();

        // random phase
        for (int i = 0; i < 600; i++) begin
            if (($urandom % 64) == 0) begin
                do_reset();
            end else begin
                step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                     (($urandom % 4) != 0), 4'($urandom), 8'($urandom));
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule